// File: doc/BRIEF.md
# Length-Configurable Byte-Serial Sequencer

This clocked control block takes a wide data word and a byte count. It then steps through the selected bytes one by one, starting with the least significant byte. Every byte gets the same fixed run of three processing phases. Between consecutive bytes there is a short idle gap of fixed length. After the final byte, the block runs a separate three-phase closing sequence and then raises a one-cycle completion pulse.

The block does none of the arithmetic that belongs to each phase. It only orders the work. It marks the active phase with one-hot strobes and presents the current byte and its index, so that downstream datapath logic can act on them. A single index counter drives the loop, so any count from zero to the word's byte capacity uses the same small set of states.

Top module: `byte_walk_seq`

## Requirements
- R1: A synchronous active-high `rst` forces the idle state. On the cycle after reset, `busy`, `done` and all six phase strobes are 0, and `cur_byte` and `cur_idx` are 0.
- R2: While idle, a high `start` at a clock edge captures `word_in` and `count_in`. If the captured count is nonzero, the next cycle is phase A of byte 0.
- R3: Byte i of the word is bits 8i+7 down to 8i. Bytes are visited in ascending index order. During phases A, B and C, `cur_byte` carries the captured byte at the current index and `cur_idx` carries that index. In every other cycle both are 0.
- R4: Each byte's phases run in the order A (`stb_a`), B (`stb_b`), C (`stb_c`), each for exactly one cycle, and the index does not change between them.
- R5: After phase C of a byte that is not the last, exactly GAP cycles (default 2) pass with no strobe and `busy` low. Phase A of the next byte follows.
- R6: After phase C of the last selected byte, the closing phases D (`stb_d`), E (`stb_e`) and F (`stb_f`) follow on three consecutive cycles.
- R7: `done` is high for exactly the one cycle after phase F. The block is idle on the cycle after that.
- R8: A captured count of 0 skips the per-byte loop: phase D comes in the cycle after the start edge.
- R9: A count above 8 is treated as 8.
- R10: `start` is ignored from the first phase cycle through the `done` cycle. Changes to `word_in` and `count_in` during a run have no effect on that run.
- R11: At most one of the six strobes and `done` is high in any cycle. `busy` is high exactly when one of `stb_a`, `stb_b` or `stb_c` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (sampled while idle) |
| word_in | input | 64 | Data word, eight bytes |
| count_in | input | 4 | Number of bytes to process (clamped to 8) |
| busy | output | 1 | High during per-byte phases A, B, C |
| cur_byte | output | 8 | Current byte during A/B/C, else 0 |
| cur_idx | output | 3 | Current byte index during A/B/C, else 0 |
| stb_a | output | 1 | Per-byte phase A strobe |
| stb_b | output | 1 | Per-byte phase B strobe |
| stb_c | output | 1 | Per-byte phase C strobe |
| stb_d | output | 1 | Closing phase D strobe |
| stb_e | output | 1 | Closing phase E strobe |
| stb_f | output | 1 | Closing phase F strobe |
| done | output | 1 | One-cycle completion pulse after F |

## Verification
The sequencer is driven with the following counts:
- Counts of 1, 3 and 8 separate the single-byte path, which has no gap, from the looped path and its gaps, and test the full-width walk.
- A count of 0 shows that the per-byte loop is skipped.
- A count of 13 shows that the count is clamped and not wrapped.

The words carry a distinct value in every byte, so a wrong lane or a wrong visiting order shows up at once. Each run holds `start` high throughout and changes `word_in` and `count_in` mid-run, which proves that these inputs are ignored until the block returns to idle. This also yields back-to-back runs. A reset in the middle of a run checks that the block recovers cleanly to idle.

// File: rtl/byte_walk_pkg.sv
package byte_walk_pkg;

    typedef enum logic [3:0] {
        WS_IDLE,
        WS_A,
        WS_B,
        WS_C,
        WS_GAP,
        WS_D,
        WS_E,
        WS_F,
        WS_DONE
    } walk_state_e;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
        logic e;
        logic f;
        logic fin;
    } strobe_t;

endpackage

// File: rtl/byte_walk_clamp.sv
module byte_walk_clamp #(
    parameter int LEN_W = 4,
    parameter int CNT_W = 4,
    parameter int LIMIT = 8
) (
    input  logic [LEN_W-1:0] len_raw,
    output logic [CNT_W-1:0] len_sat
);
    localparam logic [LEN_W-1:0] LIM_V = LEN_W'(LIMIT);

    always_comb begin
        if (len_raw > LIM_V) len_sat = CNT_W'(LIM_V);
        else                 len_sat = CNT_W'(len_raw);
    end
endmodule

// File: rtl/byte_walk_pick.sv
module byte_walk_pick #(
    parameter int BYTES  = 8,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [BYTES*BYTE_W-1:0] word,
    input  logic [IDX_W-1:0]        idx,
    input  logic                    en,
    output logic [BYTE_W-1:0]       byte_o
);
    logic [BYTE_W-1:0] lane [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lane[g] = word[g*BYTE_W +: BYTE_W];
    end

    assign byte_o = en ? lane[idx] : '0;
endmodule

// File: rtl/byte_walk_decode.sv
module byte_walk_decode
    import byte_walk_pkg::*;
(
    input  walk_state_e st,
    output strobe_t     stb
);
    always_comb begin
        stb = '0;
        case (st)
            WS_A:    stb.a   = 1'b1;
            WS_B:    stb.b   = 1'b1;
            WS_C:    stb.c   = 1'b1;
            WS_D:    stb.d   = 1'b1;
            WS_E:    stb.e   = 1'b1;
            WS_F:    stb.f   = 1'b1;
            WS_DONE: stb.fin = 1'b1;
            default: stb     = '0;
        endcase
    end
endmodule

// File: rtl/byte_walk_seq.sv
module byte_walk_seq
    import byte_walk_pkg::*;
#(
    parameter int BYTES  = 8,
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 4,
    parameter int GAP    = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start,
    input  logic [BYTES*BYTE_W-1:0]        word_in,
    input  logic [LEN_W-1:0]               count_in,
    output logic                           busy,
    output logic [BYTE_W-1:0]              cur_byte,
    output logic [$clog2(BYTES)-1:0]       cur_idx,
    output logic                           stb_a,
    output logic                           stb_b,
    output logic                           stb_c,
    output logic                           stb_d,
    output logic                           stb_e,
    output logic                           stb_f,
    output logic                           done
);
    localparam int DATA_W = BYTES * BYTE_W;
    localparam int IDX_W  = $clog2(BYTES);
    localparam int CNT_W  = $clog2(BYTES + 1);
    localparam int GAP_W  = (GAP < 1) ? 1 : $clog2(GAP + 1);
    localparam logic [GAP_W-1:0] GAP_END = GAP_W'((GAP < 1) ? 0 : GAP - 1);

    typedef struct packed {
        walk_state_e        st;
        logic [DATA_W-1:0]  word;
        logic [CNT_W-1:0]   len;
        logic [IDX_W-1:0]   idx;
        logic [GAP_W-1:0]   gap;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [CNT_W-1:0] len_sat;
    logic             last_byte;
    strobe_t          stb;

    byte_walk_clamp #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W),
        .LIMIT (BYTES)
    ) u_clamp (
        .len_raw (count_in),
        .len_sat (len_sat)
    );

    assign last_byte = (CNT_W'(r_q.idx) + CNT_W'(1)) == r_q.len;

    // Next-state computation
    always_comb begin
        r_d = r_q;
        case (r_q.st)
            WS_IDLE: begin
                if (start) begin
                    r_d.word = word_in;
                    r_d.len  = len_sat;
                    r_d.idx  = '0;
                    r_d.gap  = '0;
                    r_d.st   = (len_sat == '0) ? WS_D : WS_A;
                end
            end
            WS_A: r_d.st = WS_B;
            WS_B: r_d.st = WS_C;
            WS_C: begin
                if (last_byte) begin
                    r_d.st = WS_D;
                end else begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                    r_d.gap = '0;
                    r_d.st  = (GAP < 1) ? WS_A : WS_GAP;
                end
            end
            WS_GAP: begin
                if (r_q.gap == GAP_END) begin
                    r_d.gap = '0;
                    r_d.st  = WS_A;
                end else begin
                    r_d.gap = r_q.gap + GAP_W'(1);
                end
            end
            WS_D:    r_d.st = WS_E;
            WS_E:    r_d.st = WS_F;
            WS_F:    r_d.st = WS_DONE;
            WS_DONE: begin
                r_d.st  = WS_IDLE;
                r_d.idx = '0;
            end
            default: r_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st   <= WS_IDLE;
            r_q.word <= '0;
            r_q.len  <= '0;
            r_q.idx  <= '0;
            r_q.gap  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    byte_walk_decode u_dec (
        .st  (r_q.st),
        .stb (stb)
    );

    assign busy = (r_q.st == WS_A) || (r_q.st == WS_B) || (r_q.st == WS_C);

    byte_walk_pick #(
        .BYTES  (BYTES),
        .BYTE_W (BYTE_W),
        .IDX_W  (IDX_W)
    ) u_pick (
        .word   (r_q.word),
        .idx    (r_q.idx),
        .en     (busy),
        .byte_o (cur_byte)
    );

    assign cur_idx = busy ? r_q.idx : '0;
    assign stb_a   = stb.a;
    assign stb_b   = stb.b;
    assign stb_c   = stb.c;
    assign stb_d   = stb.d;
    assign stb_e   = stb.e;
    assign stb_f   = stb.f;
    assign done    = stb.fin;
endmodule

// File: rtl/byte_walk_seq_chk.sv
module byte_walk_seq_chk #(
    parameter int GAP   = 2,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic [IDX_W-1:0] cur_idx,
    input logic             stb_a,
    input logic             stb_b,
    input logic             stb_c,
    input logic             stb_d,
    input logic             stb_e,
    input logic             stb_f,
    input logic             done
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !stb_a && !stb_d));

    p_a_then_b_r4: assert property (@(posedge clk) disable iff (rst)
        stb_a |=> stb_b);

    p_b_then_c_r4: assert property (@(posedge clk) disable iff (rst)
        stb_b |=> stb_c);

    p_idx_held_r4: assert property (@(posedge clk) disable iff (rst)
        stb_b |=> (cur_idx == $past(cur_idx)));

    p_gap_present_r5: assert property (@(posedge clk) disable iff (rst)
        (GAP > 0) && stb_c |=> !stb_a);

    p_d_then_e_r6: assert property (@(posedge clk) disable iff (rst)
        stb_d |=> stb_e);

    p_e_then_f_r6: assert property (@(posedge clk) disable iff (rst)
        stb_e |=> stb_f);

    p_f_then_done_r7: assert property (@(posedge clk) disable iff (rst)
        stb_f |=> done);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy && !stb_a && !stb_d));

    p_strobe_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb_a, stb_b, stb_c, stb_d, stb_e, stb_f, done}));

    p_busy_match_r11: assert property (@(posedge clk) disable iff (rst)
        busy == (stb_a || stb_b || stb_c));
endmodule

bind byte_walk_seq byte_walk_seq_chk #(
    .GAP   (GAP),
    .IDX_W ($clog2(BYTES))
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .cur_idx (cur_idx),
    .stb_a   (stb_a),
    .stb_b   (stb_b),
    .stb_c   (stb_c),
    .stb_d   (stb_d),
    .stb_e   (stb_e),
    .stb_f   (stb_f),
    .done    (done)
);

// File: tb/sim_byte_walk_seq.sv
`timescale 1ns/1ps
module sim_byte_walk_seq;
    localparam int GAP = 2;

    // phase codes of the model: 0 idle, 1..3 A..C, 4 gap, 5..7 D..F, 8 done
    typedef struct {
        int ph;
        int idx;
        int byt;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] word_in = '0;
    logic [3:0]  count_in = '0;
    logic        busy, stb_a, stb_b, stb_c, stb_d, stb_e, stb_f, done;
    logic [7:0]  cur_byte;
    logic [2:0]  cur_idx;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    armed = 0;
    string scen = "R1 reset";
    exp_t  q[$];
    exp_t  cur;

    always #2.5 clk = ~clk;

    byte_walk_seq #(.GAP(GAP)) u0 (
        .clk(clk), .rst(rst), .start(start), .word_in(word_in),
        .count_in(count_in), .busy(busy), .cur_byte(cur_byte),
        .cur_idx(cur_idx), .stb_a(stb_a), .stb_b(stb_b), .stb_c(stb_c),
        .stb_d(stb_d), .stb_e(stb_e), .stb_f(stb_f), .done(done)
    );

    function automatic void push_run(logic [63:0] w, int len);
        int n = (len > 8) ? 8 : len;  // R9 clamp
        for (int i = 0; i < n; i++) begin
            for (int p = 1; p <= 3; p++) q.push_back('{p, i, int'(w[8*i +: 8])});
            if (i < n - 1)
                for (int g = 0; g < GAP; g++) q.push_back('{4, 0, 0});
        end
        for (int p = 5; p <= 8; p++) q.push_back('{p, 0, 0});
    endfunction

    // reference model: advances one expected record per clock
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            cur = '{0, 0, 0};
        end else begin
            if (start && cur.ph == 0) push_run(word_in, int'(count_in));
            if (q.size() > 0) cur = q.pop_front();
            else cur = '{0, 0, 0};
        end
        armed = 1;
    end

    function automatic string tag_of(int ph);
        case (ph)
            0: return "R1/R2 idle";
            1, 2, 3: return "R3/R4 byte phase";
            4: return "R5 gap";
            5, 6, 7: return "R6 closing";
            default: return "R7 done";
        endcase
    endfunction

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (armed) begin
            logic [6:0] exp_s, act_s;
            logic       exp_busy;
            logic [7:0] exp_b;
            logic [2:0] exp_i;
            exp_s = {cur.ph == 1, cur.ph == 2, cur.ph == 3, cur.ph == 5,
                     cur.ph == 6, cur.ph == 7, cur.ph == 8};
            act_s = {stb_a, stb_b, stb_c, stb_d, stb_e, stb_f, done};
            exp_busy = (cur.ph >= 1 && cur.ph <= 3);
            exp_b = exp_busy ? 8'(cur.byt) : 8'h00;
            exp_i = exp_busy ? 3'(cur.idx) : 3'd0;
            n_checks++;
            if (act_s !== exp_s || busy !== exp_busy || cur_byte !== exp_b
                || cur_idx !== exp_i) begin
                n_fail++;
                $display("FAIL %s [%s] t=%0t strobes=%b busy=%b byte=%h idx=%0d expected strobes=%b busy=%b byte=%h idx=%0d",
                         tag_of(cur.ph), scen, $time, act_s, busy, cur_byte, cur_idx,
                         exp_s, exp_busy, exp_b, exp_i);
            end
        end
    end

    task automatic wait_idle();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while ((cur.ph != 0 || q.size() != 0) && guard < 1000);
    endtask

    // single run; start stays high through the run (R10), inputs scrambled mid-run
    task automatic run(logic [63:0] w, logic [3:0] len, string s);
        scen = s;
        @(negedge clk);
        word_in  = w;
        count_in = len;
        start    = 1'b1;
        @(negedge clk);
        word_in  = ~w;
        count_in = 4'd5;  // R10: ignored while running
        wait_idle();
        start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        run(64'h8877_6655_4433_2211, 4'd3, "R2 R3 R5 len three");
        run(64'hF0E1_D2C3_B4A5_9687, 4'd8, "R3 R4 R6 len eight");
        run(64'h0123_4567_89AB_CDEF, 4'd0, "R8 len zero");
        run(64'h1020_3040_5060_7080, 4'd13, "R9 clamp thirteen");
        run(64'h0000_0000_0000_00A5, 4'd1, "R7 single byte");
        // R10: back-to-back runs with start held across the done cycle
        scen = "R10 start held";
        @(negedge clk);
        word_in = 64'h5A5A_3C3C_0F0F_9696;
        count_in = 4'd2;
        start = 1'b1;
        repeat (40) @(negedge clk);
        start = 1'b0;
        wait_idle();
        // R1: reset in the middle of a run
        scen = "R1 reset mid-run";
        word_in = 64'hDEAD_BEEF_CAFE_F00D;
        count_in = 4'd6;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        run(64'h1111_2222_3333_4444, 4'd4, "R2 after reset");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: run hung after %0d cycles, expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule